// File: doc/BRIEF.md
# Not-Recently-Used Replacement Unit

This block chooses which way of a set-associative cache to evict. Each set holds one hint bit per way. A 1 marks a way that has not been used lately, and only such ways are offered for eviction. A hit on a way, or a refill into it, clears that way's bit. When a set has no way left with a 1, a victim request turns every bit of that set back to 1 at the next clock edge. A way is still named as the victim in that same cycle.

The cache controller drives three independent strobes: a hit (set, way), a fill (set, way) and a victim request (set). The victim way is combinational from the state held at that moment, so it is valid in the cycle the request is high. A compile-time parameter picks the rule that chooses between several candidates: always the lowest way, a rotating pointer kept for each set, or a free-running pseudo-random generator. A read port returns the hint bits of any set, so the controller or a test can inspect the state. Tag and data storage are not part of this block.

Top module: `nru_repl`

## Requirements
- R1: During and after reset, every bit of every set reads 1 on `rd_bits`.
- R2: A hit strobe clears the bit of (`acc_set`, `acc_way`) at the next edge and leaves all other bits as they were.
- R3: A fill strobe clears the bit of (`fill_set`, `fill_way`) at the next edge and leaves all other bits as they were.
- R4: If the requested set has at least one bit at 1, the victim is a way whose bit is 1, and the request changes no state bit.
- R5: If every bit of the requested set is 0, the request sets all bits of that set to 1 at the next edge. The victim's bit stays 1 until a fill clears it, and other sets are not touched.
- R6: A hit or fill to the same set in the same cycle as such a bulk set wins for its own way: that way's bit ends at 0.
- R7: With `MODE`=0 the victim is the lowest-numbered candidate way.
- R8: With `MODE`=1 each set has a pointer that is 0 after reset. The scan starts at the pointer and wraps around, and each request moves the pointer of its set to (victim+1) mod `WAYS`.
- R9: With `MODE`=2 an 8-bit generator is seeded to 1 at reset and steps on every clock as next = {g[6:0], g[7]^g[5]^g[4]^g[3]}. The scan starts at way g[log2(WAYS)-1:0] and wraps around.
- R10: `vic_way` is valid in the same cycle as `vic_req`; bit w of `rd_bits` is the hint bit of way w of set `rd_set`, also without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Hit strobe |
| acc_set | input | log2(SETS) | Set of the hit |
| acc_way | input | log2(WAYS) | Way of the hit |
| fill_vld | input | 1 | Fill strobe |
| fill_set | input | log2(SETS) | Set being filled |
| fill_way | input | log2(WAYS) | Way being filled |
| vic_req | input | 1 | Victim request |
| vic_set | input | log2(SETS) | Set needing a victim |
| vic_way | output | log2(WAYS) | Chosen victim way |
| rd_set | input | log2(SETS) | Set to inspect |
| rd_bits | output | WAYS | Hint bits of `rd_set` |

## Verification
The bench drives a set with every bit at 0 into a victim request and reads it back. A design that forgot the bulk set would keep naming way 0 with no state change, and one that set only the victim's bit would leave the other ways at 0. A fill that arrives in the same cycle as the bulk set must keep its way cleared; a design that ordered the two the wrong way would leave that way marked as unused. Three instances, one per tie-break mode, run under the same random traffic on a few sets. This catches a pointer that does not wrap or skips a position, and a generator whose taps or phase after reset are off.

// File: rtl/nru_repl.sv
module nru_repl #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int MODE = 1,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             fill_vld,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             vic_req,
  input  logic [SET_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAYS-1:0]  rd_bits
);
  localparam int GEN_W = 8;

  logic [WAYS-1:0] nru_q [SETS];
  logic [WAYS-1:0] nru_d [SETS];
  logic [WAY_W-1:0] start;
  logic [WAY_W-1:0] idx;
  logic found;

  wire [WAYS-1:0] cur = nru_q[vic_set];
  wire all_zero = (cur == '0);
  wire [WAYS-1:0] cand = all_zero ? {WAYS{1'b1}} : cur;

  assign rd_bits = nru_q[rd_set];

  generate
    if (MODE == 1) begin : g_rot
      logic [WAY_W-1:0] ptr_q [SETS];
      assign start = ptr_q[vic_set];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        else if (vic_req) ptr_q[vic_set] <= vic_way + 1'b1;
    end else if (MODE == 2) begin : g_rnd
      logic [GEN_W-1:0] gen_q;
      assign start = gen_q[WAY_W-1:0];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) gen_q <= GEN_W'(1);
        else gen_q <= {gen_q[6:0], gen_q[7] ^ gen_q[5] ^ gen_q[4] ^ gen_q[3]};
    end else begin : g_fix
      assign start = '0;
    end
  endgenerate

  always_comb begin
    vic_way = '0;
    found = 1'b0;
    idx = '0;
    for (int k = 0; k < WAYS; k++) begin
      idx = start + WAY_W'(k);
      if (!found && cand[idx]) begin
        vic_way = idx;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      nru_d[s] = nru_q[s];
      if (vic_req && vic_set == SET_W'(s) && all_zero) nru_d[s] = {WAYS{1'b1}};
      if (acc_vld && acc_set == SET_W'(s)) nru_d[s][acc_way] = 1'b0;
      if (fill_vld && fill_set == SET_W'(s)) nru_d[s][fill_way] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int s = 0; s < SETS; s++) nru_q[s] <= {WAYS{1'b1}};
    else for (int s = 0; s < SETS; s++) nru_q[s] <= nru_d[s];
endmodule

// File: rtl/nru_repl_chk.sv
module nru_repl_chk #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int MODE = 1,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_vld,
  input logic [SET_W-1:0] acc_set,
  input logic [WAY_W-1:0] acc_way,
  input logic             fill_vld,
  input logic [SET_W-1:0] fill_set,
  input logic [WAY_W-1:0] fill_way,
  input logic             vic_req,
  input logic [SET_W-1:0] vic_set,
  input logic [WAY_W-1:0] vic_way,
  input logic [WAYS-1:0]  cur,
  input logic [WAYS-1:0]  bits [SETS]
);
  assert_candidate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_req && cur != '0) |-> cur[vic_way]);

  assert_bulk_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_req && cur == '0 && !(acc_vld && acc_set == vic_set) && !(fill_vld && fill_set == vic_set))
    |=> bits[$past(vic_set)] == {WAYS{1'b1}});

  assert_hit_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> !bits[$past(acc_set)][$past(acc_way)]);

  assert_fill_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld |=> !bits[$past(fill_set)][$past(fill_way)]);

  assert_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 0 && vic_req && cur != '0) |-> ((cur & ((WAYS'(1) << vic_way) - WAYS'(1))) == '0));
endmodule

bind nru_repl nru_repl_chk #(.SETS(SETS), .WAYS(WAYS), .MODE(MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set), .acc_way(acc_way),
  .fill_vld(fill_vld), .fill_set(fill_set), .fill_way(fill_way), .vic_req(vic_req),
  .vic_set(vic_set), .vic_way(vic_way), .cur(cur), .bits(nru_q)
);

// File: tb/test_nru_repl.sv
module test_nru_repl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_vld = 0, fill_vld = 0, vic_req = 0;
  logic [3:0] acc_set = 0, fill_set = 0, vic_set = 0, rd_set = 0;
  logic [1:0] acc_way = 0, fill_way = 0;
  logic [1:0] vw_rot, vw_fix, vw_rnd;
  logic [3:0] rb_rot, rb_fix, rb_rnd;

  int nchk = 0, nfail = 0;
  bit mb [16][4];
  int ptr [16];
  int gen;
  int er, ef, en, last_vic;

  always #2 clk = ~clk;

  nru_repl #(.MODE(1)) i_nru_repl (.clk, .rst_n, .acc_vld, .acc_set, .acc_way, .fill_vld,
    .fill_set, .fill_way, .vic_req, .vic_set, .vic_way(vw_rot), .rd_set, .rd_bits(rb_rot));
  nru_repl #(.MODE(0)) i_nru_repl_fix (.clk, .rst_n, .acc_vld, .acc_set, .acc_way, .fill_vld,
    .fill_set, .fill_way, .vic_req, .vic_set, .vic_way(vw_fix), .rd_set, .rd_bits(rb_fix));
  nru_repl #(.MODE(2)) i_nru_repl_rnd (.clk, .rst_n, .acc_vld, .acc_set, .acc_way, .fill_vld,
    .fill_set, .fill_way, .vic_req, .vic_set, .vic_way(vw_rnd), .rd_set, .rd_bits(rb_rnd));

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pick(int s, int st);
    bit any = 0;
    for (int w = 0; w < 4; w++) if (mb[s][w]) any = 1;
    for (int k = 0; k < 4; k++) begin
      int w = (st + k) % 4;
      if (!any || mb[s][w]) return w;
    end
    return 0;
  endfunction

  function automatic int packed_bits(int s);
    int v = 0;
    for (int w = 0; w < 4; w++) if (mb[s][w]) v |= (1 << w);
    return v;
  endfunction

  task automatic step(bit av, int as, int aw, bit fv, int fs, int fw, bit vr, int vs, int rs);
    bit az;
    int fb;
    @(negedge clk);
    acc_vld = av; acc_set = 4'(as); acc_way = 2'(aw);
    fill_vld = fv; fill_set = 4'(fs); fill_way = 2'(fw);
    vic_req = vr; vic_set = 4'(vs); rd_set = 4'(rs);
    #1;
    if (vr) begin
      ef = pick(vs, 0); er = pick(vs, ptr[vs]); en = pick(vs, gen % 4);
      check("R7 R10 fixed victim", int'(vw_fix), ef);
      check("R8 R10 rotating victim", int'(vw_rot), er);
      check("R9 R10 random victim", int'(vw_rnd), en);
      if (packed_bits(vs) != 0) check("R4 victim bit set", int'(mb[vs][vw_rot]), 1);
      last_vic = int'(vw_rot);
    end
    check("R2 R3 R10 state readback rot", int'(rb_rot), packed_bits(rs));
    check("R2 R3 R10 state readback fix", int'(rb_fix), packed_bits(rs));
    check("R2 R3 R10 state readback rnd", int'(rb_rnd), packed_bits(rs));
    @(posedge clk);
    az = (packed_bits(vs) == 0);
    if (vr && az) for (int w = 0; w < 4; w++) mb[vs][w] = 1;
    if (av) mb[as][aw] = 0;
    if (fv) mb[fs][fw] = 0;
    if (vr) ptr[vs] = (er + 1) % 4;
    fb = ((gen >> 7) ^ (gen >> 5) ^ (gen >> 4) ^ (gen >> 3)) & 1;
    gen = ((gen << 1) | fb) & 255;
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      ptr[s] = 0;
      for (int w = 0; w < 4; w++) mb[s][w] = 1;
    end
    gen = 1;
    repeat (3) @(posedge clk);
    foreach (ptr[s]) if (s == 0 || s == 7 || s == 15) begin
      @(negedge clk); rd_set = 4'(s); #1;
      check("R1 reset rot", int'(rb_rot), 15);
      check("R1 reset fix", int'(rb_fix), 15);
      check("R1 reset rnd", int'(rb_rnd), 15);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);
    gen = 2;

    step(1, 9, 2, 0, 0, 0, 0, 0, 9);
    step(0, 0, 0, 0, 0, 0, 0, 0, 9);
    check("R2 hit clears way 2", int'(rb_fix), 4'b1011);
    step(0, 0, 0, 1, 9, 0, 0, 0, 9);
    step(0, 0, 0, 0, 0, 0, 0, 0, 9);
    check("R3 fill clears way 0", int'(rb_fix), 4'b1010);
    step(1, 9, 1, 1, 9, 3, 0, 0, 9);
    step(0, 0, 0, 0, 0, 0, 1, 9, 9);
    step(0, 0, 0, 0, 0, 0, 0, 0, 9);
    check("R5 all ways set after bulk", int'(rb_rot), 15);
    check("R5 victim bit stays 1", int'(rb_rot[last_vic]), 1);
    step(0, 0, 0, 0, 0, 0, 1, 9, 9);
    step(0, 0, 0, 0, 0, 0, 0, 0, 9);
    check("R4 request leaves state", int'(rb_rot), 15);

    step(1, 10, 0, 1, 10, 1, 0, 0, 10);
    step(1, 10, 2, 1, 10, 3, 0, 0, 10);
    step(0, 0, 0, 1, 10, 2, 1, 10, 10);
    step(0, 0, 0, 0, 0, 0, 0, 0, 10);
    check("R6 fill wins over bulk set", int'(rb_fix), 4'b1011);
    step(0, 0, 0, 0, 0, 0, 0, 0, 11);
    check("R5 other set untouched", int'(rb_fix), 15);

    for (int i = 0; i < 3000; i++)
      step($urandom_range(1, 0) == 1, $urandom_range(3, 0), $urandom_range(3, 0),
           $urandom_range(3, 0) == 0, $urandom_range(3, 0), $urandom_range(3, 0),
           $urandom_range(2, 0) == 0, $urandom_range(3, 0), $urandom_range(3, 0));

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule